// File: doc/BRIEF.md
# Programmable LED Blink Controller

This block drives one LED pin from a slow timebase: each rising edge of its clock is one tick of a 32768 Hz source. Software programs it through three 32-bit words on a synchronous write/read bus: a configuration word, a limits word and a delay word. The configuration word selects one of four output modes: off, breathing, blink and always on. It also holds a clock-source select bit, an update-commit bit, a self-clearing soft-reset bit and an 8-bit watchdog reload field. In this block the clock-source select and the watchdog reload are plain storage.

In blink mode a prescale divider counts from zero to the prescale value (the low 12 bits of the delay word). Each time it reaches that value it advances an 8-bit up counter. The LED is lit while the counter is below the duty value (the low byte of the limits word), so one blink period lasts 256 × (prescale + 1) ticks. The usual programming sequence is to select off mode, write the prescale and duty values, then write the configuration word with blink mode and the update bit set. The new values are copied into the running timer at the next counter wrap, and the update bit then clears itself.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x00001400, the limits and delay words read 0, and `led_o` is low.
- R2: Byte address 0x0 is configuration, 0x4 is limits and 0x8 is delay. Configuration implements bits [1:0] (mode), 2 (clock select), 6 (update) and [15:8] (watchdog reload). Limits implements [7:0] (duty/minimum) and [15:8] (maximum). Delay implements [11:0] (prescale) and [23:12] (high delay). All other bits and addresses read 0, and writes to other addresses are ignored.
- R3: Mode code 0 (off) and code 1 (breathing) hold `led_o` low. Code 3 (always on) holds it high. A mode write takes effect in the cycle after its write edge.
- R4: In blink mode (code 2) the 8-bit counter starts at 0 and advances once every prescale+1 ticks. The output pattern therefore repeats every 256 × (prescale + 1) ticks.
- R5: In blink mode `led_o` is high while the counter is below the applied duty value. In each period it is high for duty × (prescale + 1) ticks, starting at the first tick of the period. A duty of 0 keeps it low.
- R6: An applied duty of 0xFF holds `led_o` high for the whole period.
- R7: Configuration bit 6 reads 1 after it is written. The written prescale and duty values are applied at the first counter wrap that follows, and bit 6 reads 0 after that.
- R8: Writing configuration with bit 7 set returns every register, the divider, the counter and the applied values to their reset values at that write edge. Bit 7 always reads 0.
- R9: Prescale and duty writes made without setting bit 6 do not change the blink output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one edge per 32768 Hz tick |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, data captured at the rising edge |
| bus_addr | input | 4 | Byte address of the word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| led_o | output | 1 | LED drive, high is lit |

## Verification
Read data is combinational, so every register value and the update-bit state are due half a cycle after the write edge. The bench samples them at the falling edge that follows the write. A mode change reaches `led_o` in the same half cycle. A committed update is applied at the wrap 256 × (old prescale + 1) ticks after the blink write. The bench counts exactly that many falling edges before it starts a high-tick count over one full new period, and it checks that the sample one period later matches the first. For the deferred-update cases the bench waits two periods, so a wrap is certain to have happened. It then counts over a 256-tick window, which holds exactly one period at any phase.

// File: rtl/led_blink_pkg.sv
// Package: shared mode encoding, word offsets, bit positions and reset values
// for the LED blink controller. Assumes a 32-bit word bus with byte addresses.
package led_blink_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_BREATH = 2'd1,
        MODE_BLINK  = 2'd2,
        MODE_ON     = 2'd3
    } led_mode_e;

    localparam int OFS_CFG = 'h0;
    localparam int OFS_LIM = 'h4;
    localparam int OFS_DLY = 'h8;

    localparam int CFG_CLKSEL_BIT = 2;
    localparam int CFG_UPD_BIT    = 6;
    localparam int CFG_SRST_BIT   = 7;
    localparam int CFG_WDT_LSB    = 8;
    localparam int WDT_W          = 8;

    localparam logic [WDT_W-1:0] WDT_DFLT = 8'h14;

endpackage

// File: rtl/led_blink_regs.sv
// Register file: holds the configuration, limits and delay words, decodes the
// byte-addressed bus, produces a one-cycle soft-reset request and clears the
// update bit when the timer reports an applied update. Assumes CNT_W <= 16 and
// PRESC_W <= 16 so every field fits in its 32-bit word.
module led_blink_regs
    import led_blink_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 8,
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               apply,
    output led_mode_e          mode,
    output logic               upd_pend,
    output logic               srst,
    output logic [PRESC_W-1:0] shd_presc,
    output logic [CNT_W-1:0]   shd_duty
);

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(OFS_LIM);
    localparam logic [ADDR_W-1:0] A_DLY = ADDR_W'(OFS_DLY);

    led_mode_e          mode_q;
    logic               clksel_q;
    logic               upd_q;
    logic [WDT_W-1:0]   wdt_q;
    logic [CNT_W-1:0]   lim_lo_q;
    logic [CNT_W-1:0]   lim_hi_q;
    logic [PRESC_W-1:0] dly_lo_q;
    logic [PRESC_W-1:0] dly_hi_q;

    logic cfg_wr;
    logic lim_wr;
    logic dly_wr;

    // Purpose: decode the write strobe per word and detect a soft-reset request.
    always_comb begin
        cfg_wr = wr && (addr == A_CFG);
        lim_wr = wr && (addr == A_LIM);
        dly_wr = wr && (addr == A_DLY);
        srst   = cfg_wr && wdata[CFG_SRST_BIT];
    end

    // Purpose: configuration word storage, soft reset and self-clearing update bit.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            mode_q   <= MODE_OFF;
            clksel_q <= 1'b0;
            upd_q    <= 1'b0;
            wdt_q    <= WDT_DFLT;
        end else if (cfg_wr) begin
            mode_q   <= led_mode_e'(wdata[1:0]);
            clksel_q <= wdata[CFG_CLKSEL_BIT];
            upd_q    <= wdata[CFG_UPD_BIT];
            wdt_q    <= wdata[CFG_WDT_LSB +: WDT_W];
        end else if (apply) begin
            upd_q    <= 1'b0;
        end
    end

    // Purpose: limits and delay word storage.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            lim_lo_q <= '0;
            lim_hi_q <= '0;
            dly_lo_q <= '0;
            dly_hi_q <= '0;
        end else begin
            if (lim_wr) begin
                lim_lo_q <= wdata[0 +: CNT_W];
                lim_hi_q <= wdata[CNT_W +: CNT_W];
            end
            if (dly_wr) begin
                dly_lo_q <= wdata[0 +: PRESC_W];
                dly_hi_q <= wdata[PRESC_W +: PRESC_W];
            end
        end
    end

    // Purpose: assemble read data; unimplemented bits and addresses read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG: begin
                rdata[1:0]                   = mode_q;
                rdata[CFG_CLKSEL_BIT]        = clksel_q;
                rdata[CFG_UPD_BIT]           = upd_q;
                rdata[CFG_WDT_LSB +: WDT_W]  = wdt_q;
            end
            A_LIM: begin
                rdata[0 +: CNT_W]            = lim_lo_q;
                rdata[CNT_W +: CNT_W]        = lim_hi_q;
            end
            A_DLY: begin
                rdata[0 +: PRESC_W]          = dly_lo_q;
                rdata[PRESC_W +: PRESC_W]    = dly_hi_q;
            end
            default: rdata = '0;
        endcase
    end

    assign mode      = mode_q;
    assign upd_pend  = upd_q;
    assign shd_presc = dly_lo_q;
    assign shd_duty  = lim_lo_q;

    AST_SRST_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (mode_q == MODE_OFF && !upd_q && wdt_q == WDT_DFLT && lim_lo_q == '0)); // R8
    AST_UPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && apply && !cfg_wr) |=> !upd_q); // R7

endmodule

// File: rtl/led_blink_timer.sv
// Blink timer: a prescale divider steps an up counter while blink mode is
// selected. At each counter wrap with an update pending it copies the shadow
// prescale and duty into the applied registers and pulses apply. Assumes run
// and srst come straight from the register file in the same clock domain.
module led_blink_timer #(
    parameter int CNT_W   = 8,
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               srst,
    input  logic               upd_pend,
    input  logic [PRESC_W-1:0] shd_presc,
    input  logic [CNT_W-1:0]   shd_duty,
    output logic               apply,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   act_duty
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [PRESC_W-1:0] div_q;
    logic [PRESC_W-1:0] act_presc_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   act_duty_q;
    logic               step;

    // Purpose: flag a counter step and an update due at the wrap.
    always_comb begin
        step  = run && (div_q == act_presc_q);
        apply = step && (cnt_q == CNT_MAX) && upd_pend;
    end

    // Purpose: divider and counter; both held at zero outside blink mode.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (!run) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            div_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Purpose: applied prescale and duty, loaded only at an update wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            act_presc_q <= '0;
            act_duty_q  <= '0;
        end else if (apply) begin
            act_presc_q <= shd_presc;
            act_duty_q  <= shd_duty;
        end
    end

    assign cnt      = cnt_q;
    assign act_duty = act_duty_q;

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= act_presc_q); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !srst && div_q != act_presc_q) |=> $stable(cnt_q)); // R4
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !srst) |=> ($stable(act_duty_q) && $stable(act_presc_q))); // R9

endmodule

// File: rtl/led_blink_out.sv
// Output selector: turns the mode, the counter and the applied duty into the
// LED drive. Off and breathing drive low, always-on drives high, and blink
// compares the counter with the duty, with an all-ones duty forcing full on.
// The clock and reset are used only by the assertions.
module led_blink_out
    import led_blink_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  led_mode_e        mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_duty,
    output logic             led
);

    localparam logic [CNT_W-1:0] DUTY_FULL = {CNT_W{1'b1}};

    // Purpose: select the LED level for the current mode.
    always_comb begin
        case (mode)
            MODE_ON:    led = 1'b1;
            MODE_BLINK: led = (act_duty == DUTY_FULL) || (cnt < act_duty);
            default:    led = 1'b0;
        endcase
    end

    AST_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ON) |-> led); // R3
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF || mode == MODE_BREATH) |-> !led); // R3
    AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BLINK && act_duty == DUTY_FULL) |-> led); // R6

endmodule

// File: rtl/led_blink_ctrl.sv
// Top level of the LED blink controller: connects the register file, the blink
// timer and the output selector. Assumes clk is the 32768 Hz timebase itself
// and rst_n is synchronous to it.
module led_blink_ctrl
    import led_blink_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 8,
    parameter int PRESC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              led_o
);

    led_mode_e          mode;
    logic               upd_pend;
    logic               srst;
    logic               apply;
    logic [PRESC_W-1:0] shd_presc;
    logic [CNT_W-1:0]   shd_duty;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   act_duty;
    logic               run;

    // Purpose: the timer runs only in blink mode.
    assign run = (mode == MODE_BLINK);

    led_blink_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .PRESC_W(PRESC_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .apply    (apply),
        .mode     (mode),
        .upd_pend (upd_pend),
        .srst     (srst),
        .shd_presc(shd_presc),
        .shd_duty (shd_duty)
    );

    led_blink_timer #(
        .CNT_W  (CNT_W),
        .PRESC_W(PRESC_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .srst     (srst),
        .upd_pend (upd_pend),
        .shd_presc(shd_presc),
        .shd_duty (shd_duty),
        .apply    (apply),
        .cnt      (cnt),
        .act_duty (act_duty)
    );

    led_blink_out #(
        .CNT_W(CNT_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .cnt     (cnt),
        .act_duty(act_duty),
        .led     (led_o)
    );

endmodule

// File: tb/led_blink_ctrl_tb.sv
module led_blink_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        led_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Blink vectors: {prescale[11:0], duty[7:0]}.
    localparam int NVEC = 6;
    localparam logic [19:0] VEC [NVEC] = '{
        {12'd0, 8'h80}, {12'd1, 8'h40}, {12'd3, 8'h01},
        {12'd0, 8'hFF}, {12'd2, 8'h00}, {12'd0, 8'hFE}
    };

    always #5 clk = ~clk;

    led_blink_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .led_o    (led_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write one word; returns at the falling edge after the capturing edge.
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    // Count high samples over n consecutive falling edges, starting now.
    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (led_o) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hi;
        logic first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_check(4'h0, 32'h0000_1400, "R1 cfg reset");
        rd_check(4'h4, 32'h0, "R1 limits reset");
        rd_check(4'h8, 32'h0, "R1 delay reset");
        check(led_o == 1'b0, "R1 led reset", led_o, 0);

        // R2 field masks and unmapped address
        wr_reg(4'h4, 32'hFFFF_FFFF);
        rd_check(4'h4, 32'h0000_FFFF, "R2 limits mask");
        wr_reg(4'h8, 32'hFFFF_FFFF);
        rd_check(4'h8, 32'h00FF_FFFF, "R2 delay mask");
        wr_reg(4'hC, 32'hFFFF_FFFF);
        rd_check(4'hC, 32'h0, "R2 unmapped reads zero");
        wr_reg(4'h0, 32'hFFFF_FF7F);
        rd_check(4'h0, 32'h0000_FF47, "R2 cfg mask");
        check(led_o == 1'b1, "R3 always on", led_o, 1);

        // R3 off and breathing
        wr_reg(4'h0, 32'h0000_1400);
        check(led_o == 1'b0, "R3 off low", led_o, 0);
        wr_reg(4'h0, 32'h0000_1401);
        check(led_o == 1'b0, "R3 breathing low", led_o, 0);

        // R8 soft reset
        wr_reg(4'h0, 32'h0000_FF83);
        rd_check(4'h0, 32'h0000_1400, "R8 cfg after soft reset");
        rd_check(4'h4, 32'h0, "R8 limits after soft reset");
        rd_check(4'h8, 32'h0, "R8 delay after soft reset");

        // Vector table: R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            int p;
            int duty;
            int per;
            int exp_hi;
            p = int'(VEC[v][19:8]);
            duty = int'(VEC[v][7:0]);
            per = 256 * (p + 1);
            exp_hi = (duty == 255) ? per : duty * (p + 1);
            wr_reg(4'h0, 32'h0000_0080);
            wr_reg(4'h8, {20'h0, VEC[v][19:8]});
            wr_reg(4'h4, {24'h0, VEC[v][7:0]});
            wr_reg(4'h0, 32'h0000_1442);
            rd_check(4'h0, 32'h0000_1442, "R7 update bit pending");
            repeat (256) @(negedge clk);
            rd_check(4'h0, 32'h0000_1402, "R7 update bit cleared");
            first = led_o;
            check(first == (duty != 0), "R5 first tick level", first, duty != 0);
            count_high(per, hi);
            if (duty == 255)
                check(hi == exp_hi, "R6 full on count", hi, exp_hi);
            else
                check(hi == exp_hi, "R5 high ticks per period", hi, exp_hi);
            check(led_o == first, "R4 period repeats", led_o, first);
        end

        // R9 and R7 deferred update
        wr_reg(4'h0, 32'h0000_0080);
        wr_reg(4'h4, 32'h0000_0080);
        wr_reg(4'h0, 32'h0000_1442);
        repeat (512) @(negedge clk);
        count_high(256, hi);
        check(hi == 128, "R5 baseline duty", hi, 128);
        wr_reg(4'h4, 32'h0000_0010);
        repeat (512) @(negedge clk);
        count_high(256, hi);
        check(hi == 128, "R9 no commit no change", hi, 128);
        wr_reg(4'h0, 32'h0000_1442);
        rd_check(4'h0, 32'h0000_1442, "R7 update pending while running");
        repeat (512) @(negedge clk);
        count_high(256, hi);
        check(hi == 16, "R7 committed duty", hi, 16);
        rd_check(4'h0, 32'h0000_1402, "R7 update bit self-clears");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule